// File: doc/BRIEF.md
# Multi-Channel Grayscale PWM Timing Controller

This block turns a per-channel grayscale value into on/off enables for a bank of constant-current LED sinks. A grayscale clock enable (`gs_tick`) advances one shared counter, and each tick is one time slot of a display period of 2^GS_W slots. For every slot, each channel's enable is set from its grayscale value and the current slot.

A 13-bit function control word is loaded through `fc_wr`. It selects:
- blanking,
- single-shot or auto-repeat display periods,
- whether a latch strobe restarts the display timing,
- conventional PWM or an enhanced-spectrum mode that spreads the on-time over the period.

The same word also holds threshold selections for the external open and short detectors, which the block passes straight through. It also holds a capture point at which `fault_cap` tells the fault detectors to sample.

Grayscale values are written per channel into a first-stage register. A rising edge on `gs_lat` copies all of them into a second stage, and only the second stage drives the PWM compare.

Top module: `gs_pwm_ctrl`

## Requirements
- R1: After reset the control word has blank = 1 and every other field 0, `out_en` is all zeros and `fault_cap` is 0. Ticks leave every output off until blank is cleared.
- R2: While blank (control bit 0) is 1, every `out_en` bit is 0 from the next cycle on and the counter is held at 0. After blank returns to 0, the first tick evaluates slot 0.
- R3: With control bit 3 = 0 (conventional mode), channel n is on in slot k exactly when k < GS[n]. A value of 0 is never on, and 2^GS_W-1 is on for all but the last slot.
- R4: With control bit 3 = 1 (enhanced-spectrum mode), the period is split into 2^SEG_BITS segments of 2^(GS_W-SEG_BITS) slots. In segment s at offset o, channel n is on when o < GS[n] >> SEG_BITS plus one if s < GS[n] mod 2^SEG_BITS. The total on-slots per period equal GS[n].
- R5: With control bit 1 = 0 (single-shot), one display period runs after blank is released and all outputs then stay off, whatever further ticks arrive.
- R6: With control bit 1 = 1 (auto-repeat), the counter wraps after 2^GS_W ticks and the next period repeats the same pattern from slot 0.
- R7: `gs_wr` writes only the first stage. The outputs keep following the old values until a rising edge on `gs_lat` copies all channels into the second stage.
- R8: With control bit 2 = 1 (timing reset), a rising edge on `gs_lat` forces `out_en` to 0 in the next cycle and clears the counter. A tick in that same cycle is dropped, and the next tick evaluates slot 0.
- R9: With control bit 2 = 0, a rising edge on `gs_lat` updates the values but leaves the counter running, so the next tick evaluates the following slot.
- R10: `fault_cap` is a one-cycle pulse, aligned with `out_en`, for the tick that evaluates slot cap_sel * 2^(GS_W-2), where cap_sel is control bits 10:9.
  - With auto-repeat on and control bit 4 (repeat capture) = 0, it fires only once after each latch edge.
  - Otherwise it fires in every period.
- R11: Control bits 6:5 appear on `open_sel` and bits 8:7 on `short_sel` from the cycle after the write. Bits 12:11 are reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gs_tick | input | 1 | Grayscale clock enable, one pulse per slot |
| fc_wr | input | 1 | Load `fc_data` into the control word |
| fc_data | input | 13 | Function control word |
| gs_wr | input | 1 | Write `gs_data` into first stage of channel `gs_ch` |
| gs_ch | input | CH_W | Channel index for a grayscale write |
| gs_data | input | GS_W | Grayscale value |
| gs_lat | input | 1 | Latch strobe; rising edge transfers first to second stage |
| out_en | output | NUM_CH | Registered output enables |
| fault_cap | output | 1 | Fault-status capture pulse |
| open_sel | output | 2 | Open-detect threshold selection |
| short_sel | output | 2 | Short-detect threshold selection |

## Verification
The hardest case to reach is a latch edge that lands in the middle of a running period. It has to land in the same cycle as a tick, and it has to arrive with and without timing reset. The bench stops the tick stream partway through a period, then raises `gs_lat` and `gs_tick` together on the same edge. It then checks that the output drops, that the tick is lost, and that the slot pattern restarts at 0 (or continues, when timing reset is off). The once-only capture rule also needs several periods back to back with no latch between them. The bench therefore counts capture pulses over consecutive auto-repeat periods, against randomly seeded grayscale values mixed with boundary values.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

  localparam int FC_W = 13;

  // Function control word, blank in bit 0.
  typedef struct packed {
    logic [1:0] rsvd;       // 12:11
    logic [1:0] cap_sel;    // 10:9
    logic [1:0] short_sel;  // 8:7
    logic [1:0] open_sel;   // 6:5
    logic       fault_rpt;  // 4
    logic       es_mode;    // 3
    logic       tmg_rst;    // 2
    logic       auto_rpt;   // 1
    logic       blank;      // 0
  } fc_t;

  localparam fc_t FC_RESET = '{rsvd: 2'b00, cap_sel: 2'b00, short_sel: 2'b00,
                               open_sel: 2'b00, fault_rpt: 1'b0, es_mode: 1'b0,
                               tmg_rst: 1'b0, auto_rpt: 1'b0, blank: 1'b1};

endpackage

// File: rtl/gs_latch.sv
module gs_latch #(
  parameter int NUM_CH = 16,
  parameter int GS_W   = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [GS_W-1:0]          wr_data,
  input  logic                     load,
  output logic [NUM_CH*GS_W-1:0]   gs_flat
);

  logic [GS_W-1:0] stage1 [NUM_CH];

  // First stage: one write port, no reset needed.
  always_ff @(posedge clk) begin
    if (wr) stage1[wr_ch] <= wr_data;
  end

  // Second stage: every channel is copied at once on a load.
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_stage2
      always_ff @(posedge clk) begin
        if (rst)       gs_flat[g*GS_W +: GS_W] <= '0;
        else if (load) gs_flat[g*GS_W +: GS_W] <= stage1[g];
      end
    end
  endgenerate

endmodule

// File: rtl/gs_timebase.sv
module gs_timebase #(
  parameter int GS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            tick,
  input  logic            auto_rpt,
  output logic            step,
  output logic            done,
  output logic [GS_W-1:0] cnt
);

  localparam logic [GS_W-1:0] LAST = {GS_W{1'b1}};

  assign step = tick & ~done & ~clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST && !auto_rpt) done <= 1'b1;
    end
  end

endmodule

// File: rtl/gs_pwm_bank.sv
module gs_pwm_bank #(
  parameter int NUM_CH     = 16,
  parameter int GS_W       = 16,
  parameter int SEG_BITS   = 7,
  parameter bit ES_SUPPORT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   tick,
  input  logic                   step,
  input  logic                   es_mode,
  input  logic [GS_W-1:0]        cnt,
  input  logic [NUM_CH*GS_W-1:0] gs_flat,
  output logic [NUM_CH-1:0]      out_en
);

  localparam int OFF_W = GS_W - SEG_BITS;

  logic                es_sel;
  logic [SEG_BITS-1:0] seg;
  logic [OFF_W-1:0]    off;
  logic [NUM_CH-1:0]   on_vec;

  generate
    if (ES_SUPPORT) begin : g_es
      assign es_sel = es_mode;
    end else begin : g_no_es
      assign es_sel = 1'b0;
    end
  endgenerate

  assign seg = cnt[GS_W-1 -: SEG_BITS];
  assign off = cnt[OFF_W-1:0];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic [GS_W-1:0]     gs;
      logic [OFF_W-1:0]    base;
      logic [SEG_BITS-1:0] rem;
      logic [OFF_W:0]      thr;
      assign gs   = gs_flat[g*GS_W +: GS_W];
      assign base = gs[GS_W-1:SEG_BITS];
      assign rem  = gs[SEG_BITS-1:0];
      assign thr  = {1'b0, base} + {{OFF_W{1'b0}}, (seg < rem)};
      assign on_vec[g] = es_sel ? ({1'b0, off} < thr) : (cnt < gs);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) out_en <= '0;
    else if (tick)    out_en <= step ? on_vec : '0;
  end

endmodule

// File: rtl/gs_pwm_ctrl.sv
module gs_pwm_ctrl
  import gs_pwm_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int GS_W       = 16,
  parameter int SEG_BITS   = 7,
  parameter bit ES_SUPPORT = 1'b1,
  parameter int CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gs_tick,
  input  logic              fc_wr,
  input  logic [FC_W-1:0]   fc_data,
  input  logic              gs_wr,
  input  logic [CH_W-1:0]   gs_ch,
  input  logic [GS_W-1:0]   gs_data,
  input  logic              gs_lat,
  output logic [NUM_CH-1:0] out_en,
  output logic              fault_cap,
  output logic [1:0]        open_sel,
  output logic [1:0]        short_sel
);

  fc_t                   fc_q;
  logic                  lat_q;
  logic                  lat_rise;
  logic                  restart;
  logic                  clear;
  logic                  step;
  logic                  done;
  logic                  armed;
  logic                  cap_fire;
  logic [GS_W-1:0]       cnt;
  logic [GS_W-1:0]       cap_point;
  logic [NUM_CH*GS_W-1:0] gs_flat;

  always_ff @(posedge clk) begin
    if (rst)        fc_q <= FC_RESET;
    else if (fc_wr) fc_q <= fc_t'(fc_data);
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= 1'b0;
    else     lat_q <= gs_lat;
  end

  assign lat_rise = gs_lat & ~lat_q;
  assign restart  = lat_rise & fc_q.tmg_rst;
  assign clear    = fc_q.blank | restart;

  gs_latch #(.NUM_CH(NUM_CH), .GS_W(GS_W), .CH_W(CH_W)) latch_i (
    .clk(clk), .rst(rst), .wr(gs_wr), .wr_ch(gs_ch), .wr_data(gs_data),
    .load(lat_rise), .gs_flat(gs_flat)
  );

  gs_timebase #(.GS_W(GS_W)) tb_i (
    .clk(clk), .rst(rst), .clear(clear), .tick(gs_tick),
    .auto_rpt(fc_q.auto_rpt), .step(step), .done(done), .cnt(cnt)
  );

  gs_pwm_bank #(.NUM_CH(NUM_CH), .GS_W(GS_W), .SEG_BITS(SEG_BITS),
                .ES_SUPPORT(ES_SUPPORT)) bank_i (
    .clk(clk), .rst(rst), .clear(clear), .tick(gs_tick), .step(step),
    .es_mode(fc_q.es_mode), .cnt(cnt), .gs_flat(gs_flat), .out_en(out_en)
  );

  // Fault capture: fixed slot per period, optionally once per latch.
  assign cap_point = {fc_q.cap_sel, {(GS_W-2){1'b0}}};
  assign cap_fire  = step && (cnt == cap_point) &&
                     (fc_q.fault_rpt || !fc_q.auto_rpt || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      fault_cap <= 1'b0;
    end else begin
      fault_cap <= cap_fire;
      if (lat_rise)      armed <= 1'b1;
      else if (cap_fire) armed <= 1'b0;
    end
  end

  assign open_sel  = fc_q.open_sel;
  assign short_sel = fc_q.short_sel;

endmodule

// File: rtl/gs_pwm_ctrl_chk.sv
module gs_pwm_ctrl_chk #(
  parameter int NUM_CH = 16,
  parameter int GS_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              blank,
  input logic              tmg_rst,
  input logic              done,
  input logic              gs_lat,
  input logic              gs_tick,
  input logic              fault_cap,
  input logic [GS_W-1:0]   cnt,
  input logic [NUM_CH-1:0] out_en
);

  p_blank_off_r2: assert property (@(posedge clk) disable iff (rst)
    blank |=> (out_en == '0));

  p_blank_cnt_r2: assert property (@(posedge clk) disable iff (rst)
    blank |=> (cnt == '0));

  p_tmgrst_off_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(gs_lat) && tmg_rst) |=> (out_en == '0));

  p_single_off_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !blank) |=> (out_en == '0));

  p_cap_tick_r10: assert property (@(posedge clk) disable iff (rst)
    fault_cap |-> $past(gs_tick));

  p_cap_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    fault_cap |=> !fault_cap);

endmodule

bind gs_pwm_ctrl gs_pwm_ctrl_chk #(.NUM_CH(NUM_CH), .GS_W(GS_W)) chk_i (
  .clk(clk), .rst(rst), .blank(fc_q.blank), .tmg_rst(fc_q.tmg_rst),
  .done(done), .gs_lat(gs_lat), .gs_tick(gs_tick), .fault_cap(fault_cap),
  .cnt(cnt), .out_en(out_en)
);

// File: tb/gs_pwm_ctrl_tb_top.sv
module gs_pwm_ctrl_tb_top;

  localparam int NCH  = 16;
  localparam int GW   = 10;
  localparam int SB   = 3;
  localparam int PER  = 1 << GW;
  localparam int SEGL = 1 << (GW - SB);
  localparam int NSEG = 1 << SB;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           gs_tick = 1'b0;
  logic           fc_wr = 1'b0;
  logic [12:0]    fc_data = '0;
  logic           gs_wr = 1'b0;
  logic [3:0]     gs_ch = '0;
  logic [GW-1:0]  gs_data = '0;
  logic           gs_lat = 1'b0;
  logic [NCH-1:0] out_en;
  logic           fault_cap;
  logic [1:0]     open_sel;
  logic [1:0]     short_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int stg1 [NCH];
  int stg2 [NCH];
  int on_cnt [NCH];
  int pat_err;
  int cap_cnt;
  int cap_slot;

  always #4 clk = ~clk;

  gs_pwm_ctrl #(.NUM_CH(NCH), .GS_W(GW), .SEG_BITS(SB)) dut_i (
    .clk(clk), .rst(rst), .gs_tick(gs_tick), .fc_wr(fc_wr), .fc_data(fc_data),
    .gs_wr(gs_wr), .gs_ch(gs_ch), .gs_data(gs_data), .gs_lat(gs_lat),
    .out_en(out_en), .fault_cap(fault_cap), .open_sel(open_sel),
    .short_sel(short_sel)
  );

  function automatic bit exp_on(int gs, int k, bit es);
    int seg_quota;
    if (!es) return k < gs;
    seg_quota = gs / NSEG;
    if ((k / SEGL) < (gs % NSEG)) seg_quota++;
    return (k % SEGL) < seg_quota;
  endfunction

  function automatic logic [12:0] fc(bit blank, bit rpt, bit tmg, bit es,
                                     bit frpt, int opn, int sht, int cap);
    return {2'b00, 2'(cap), 2'(sht), 2'(opn), frpt, es, tmg, rpt, blank};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr_fc(logic [12:0] v);
    fc_wr = 1'b1; fc_data = v;
    @(negedge clk);
    fc_wr = 1'b0;
  endtask

  task automatic wr_gs(int ch, int v);
    gs_wr = 1'b1; gs_ch = 4'(ch); gs_data = GW'(v);
    stg1[ch] = v;
    @(negedge clk);
    gs_wr = 1'b0;
  endtask

  task automatic load_random(bit corners);
    for (int c = 0; c < NCH; c++) begin
      int v;
      v = int'($urandom % PER);
      if (corners) begin
        case (c)
          0: v = 0;
          1: v = PER - 1;
          2: v = 1;
          3: v = SEGL - 1;
          4: v = SEGL;
          5: v = PER / 2;
          6: v = NSEG - 1;
          default: ;
        endcase
      end
      wr_gs(c, v);
    end
  endtask

  task automatic pulse_lat();
    gs_lat = 1'b1;
    @(negedge clk);
    gs_lat = 1'b0;
    for (int c = 0; c < NCH; c++) stg2[c] = stg1[c];
    @(negedge clk);
  endtask

  task automatic run_ticks(int n, int start, bit es, bit live);
    pat_err = 0; cap_cnt = 0; cap_slot = -1;
    for (int c = 0; c < NCH; c++) on_cnt[c] = 0;
    gs_tick = 1'b1;
    for (int j = 0; j < n; j++) begin
      int slot;
      @(negedge clk);
      slot = (start + j) % PER;
      for (int c = 0; c < NCH; c++) begin
        bit e;
        e = live ? exp_on(stg2[c], slot, es) : 1'b0;
        if (out_en[c] !== e) pat_err++;
        if (out_en[c] === 1'b1) on_cnt[c]++;
      end
      if (fault_cap === 1'b1) begin
        cap_cnt++;
        cap_slot = slot;
      end
    end
    gs_tick = 1'b0;
  endtask

  task automatic check_totals(string req);
    for (int c = 0; c < NCH; c++) check(on_cnt[c] == stg2[c], req, on_cnt[c], stg2[c]);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < NCH; c++) begin stg1[c] = 0; stg2[c] = 0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, ticks leave outputs off
    check(out_en == '0, "R1", int'(out_en), 0);
    check(fault_cap == 1'b0, "R1", int'(fault_cap), 0);
    run_ticks(50, 0, 1'b0, 1'b0);
    check(pat_err == 0, "R1", pat_err, 0);

    // R3/R10/R11: conventional, auto-repeat, capture at slot PER/4
    load_random(1'b1);
    pulse_lat();
    wr_fc(fc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1, 1));
    check(open_sel == 2'd2, "R11", int'(open_sel), 2);
    check(short_sel == 2'd1, "R11", int'(short_sel), 1);
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R3", pat_err, 0);
    check_totals("R3");
    check(cap_cnt == 1, "R10", cap_cnt, 1);
    check(cap_slot == PER / 4, "R10", cap_slot, PER / 4);

    // R6: second period repeats; R10: no second capture without latch
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R6", pat_err, 0);
    check(cap_cnt == 0, "R10", cap_cnt, 0);

    // R10: repeat-capture bit makes it fire every period
    wr_fc(fc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0, 2));
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(cap_cnt == 1, "R10", cap_cnt, 1);
    check(cap_slot == PER / 2, "R10", cap_slot, PER / 2);

    // R7: first-stage write alone changes nothing
    load_random(1'b0);
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R7", pat_err, 0);
    pulse_lat();
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R7", pat_err, 0);

    // R4: enhanced-spectrum
    wr_fc(fc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 0));
    load_random(1'b1);
    pulse_lat();
    run_ticks(PER, 0, 1'b1, 1'b1);
    check(pat_err == 0, "R4", pat_err, 0);
    check_totals("R4");

    // R2: blank mid-period
    wr_fc(fc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0));
    run_ticks(300, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R2", pat_err, 0);
    wr_fc(fc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0));
    @(negedge clk);
    check(out_en == '0, "R2", int'(out_en), 0);
    run_ticks(50, 0, 1'b0, 1'b0);
    check(pat_err == 0, "R2", pat_err, 0);
    wr_fc(fc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0));
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R2", pat_err, 0);

    // R5: single shot, then off; capture fires in that period
    wr_fc(fc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 3));
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R5", pat_err, 0);
    check(cap_cnt == 1, "R10", cap_cnt, 1);
    run_ticks(200, 0, 1'b0, 1'b0);
    check(pat_err == 0, "R5", pat_err, 0);
    check(cap_cnt == 0, "R5", cap_cnt, 0);

    // R8: timing reset with latch and tick on the same edge
    wr_fc(fc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 0));
    wr_fc(fc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 0));
    run_ticks(400, 0, 1'b0, 1'b1);
    check(out_en[1] == 1'b1, "R8", int'(out_en[1]), 1);
    load_random(1'b0);
    wr_gs(1, PER - 1);
    gs_lat = 1'b1; gs_tick = 1'b1;
    @(negedge clk);
    gs_lat = 1'b0;
    for (int c = 0; c < NCH; c++) stg2[c] = stg1[c];
    check(out_en == '0, "R8", int'(out_en), 0);
    run_ticks(PER, 0, 1'b0, 1'b1);
    check(pat_err == 0, "R8", pat_err, 0);
    check_totals("R8");

    // R9: latch without timing reset keeps the counter running
    wr_fc(fc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0));
    run_ticks(300, 0, 1'b0, 1'b1);
    load_random(1'b0);
    pulse_lat();
    run_ticks(PER - 300, 300, 1'b0, 1'b1);
    check(pat_err == 0, "R9", pat_err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule